// File: doc/BRIEF.md
# Die Temperature Stage Alarm

This block watches a digitized die temperature and classifies it into one of four over-temperature stages (0 = normal, 1 to 3 = increasingly severe). Three stage limits are derived from one shared two-bit offset, so software moves all of them together in 5 °C steps. Each limit has 2 °C of hysteresis: a stage is entered on reaching its limit and left only once the temperature drops 2 °C under it. Any stage change, up or down, raises a one-cycle interrupt pulse.

Temperature arrives as an unsigned count of 0.5 °C units with a valid strobe, and the stage is re-evaluated only on strobed samples. A byte-wide register port gives access to two fixed identification bytes, the stage status, the limit offset and an alarm enable. While the enable is clear the stage is forced to 0 and no interrupt is raised.

Top module: `die_temp_alarm`

## Requirements
- R1: After reset the stage is 0, the limit offset is 0, the enable is clear and the interrupt is low.
- R2: Reading offset 0x04 returns 0x09 and reading offset 0x05 returns 0x08; writes there change nothing.
- R3: With the alarm enabled, a valid sample raises the stage to the number of limits the sample is at or above, where limit k (k = 0, 1, 2) in 0.5 °C units is 210 + 10·offset + 40·k.
- R4: The limit offset is written and read in bits [1:0] of offset 0x40 (other bits read 0); it shifts all three limits together.
- R5: A stage s > 0 is left only when a valid sample is strictly below limit s-1 minus 4 units; the new stage is the number of limits the sample is not more than 4 units under.
- R6: The interrupt is high for exactly the cycle after any clock edge at which the stage changed while enabled, in either direction, and low otherwise.
- R7: The enable is bit 7 of offset 0x46 (other bits read 0). While it is clear the stage reads 0 and no interrupt is generated.
- R8: The stage changes only on samples marked valid; an unstrobed temperature has no effect.
- R9: Reads of unmapped offsets return 0x00 and writes to them or to the read-only offsets are ignored.
- R10: The stage is readable in bits [1:0] of offset 0x08 with the upper bits 0, and is also driven on the stage output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | TEMP_W (9) | Die temperature, 0.5 °C per unit |
| temp_valid_i | input | 1 | Sample strobe for temp_i |
| reg_addr_i | input | 8 | Register offset |
| reg_wen_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| stage_o | output | 2 | Current stage |
| irq_o | output | 1 | One-cycle pulse on stage change |

## Verification
For every offset setting the temperature is ramped one unit at a time from cold to past the top limit and back, which separates the entering edge (at the limit) from the leaving edge (more than 4 units under it) and shows the interrupt fires once per step and never between steps. Single-sample jumps across several limits, in both directions, distinguish a multi-stage move from a one-stage step. Disabling mid-alarm, unstrobed temperature changes, and writes to unmapped or read-only offsets show the stage and register state hold.

// File: rtl/dta_pkg.sv
package dta_pkg;
  localparam logic [7:0] ADDR_ID    = 8'h04;
  localparam logic [7:0] ADDR_SUBID = 8'h05;
  localparam logic [7:0] ADDR_STAT  = 8'h08;
  localparam logic [7:0] ADDR_LIMIT = 8'h40;
  localparam logic [7:0] ADDR_ENA   = 8'h46;
  localparam logic [7:0] ID_VAL     = 8'h09;
  localparam logic [7:0] SUBID_VAL  = 8'h08;
  localparam int         NLIMIT     = 3;
  typedef logic [1:0] stage_t;
endpackage

// File: rtl/dta_rst_sync.sv
module dta_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_n_sync = sr_q[1];
endmodule

// File: rtl/dta_regs.sv
module dta_regs
  import dta_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr_i,
  input  logic       wen_i,
  input  logic [7:0] wdata_i,
  input  stage_t     stage_i,
  output logic [7:0] rdata_o,
  output logic [1:0] sel_o,
  output logic       en_o
);
  logic [1:0] sel_q, sel_d;
  logic       en_q, en_d;
  logic       sel_we, en_we;

  assign sel_we = wen_i && (addr_i == ADDR_LIMIT);
  assign en_we  = wen_i && (addr_i == ADDR_ENA);

  always_comb begin
    sel_d = sel_q;
    en_d  = en_q;
    if (sel_we) sel_d = wdata_i[1:0];
    if (en_we)  en_d  = wdata_i[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'b00;
      en_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i)
      ADDR_ID:    rdata_o = ID_VAL;
      ADDR_SUBID: rdata_o = SUBID_VAL;
      ADDR_STAT:  rdata_o = {6'b0, stage_i};
      ADDR_LIMIT: rdata_o = {6'b0, sel_q};
      ADDR_ENA:   rdata_o = {en_q, 7'b0};
      default:    rdata_o = 8'h00;
    endcase
  end

  assign sel_o = sel_q;
  assign en_o  = en_q;

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_i && addr_i != ADDR_LIMIT && addr_i != ADDR_ENA) |=> ($stable(sel_q) && $stable(en_q)));
  assert_limit_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_i && addr_i == ADDR_LIMIT) |=> (sel_q == $past(wdata_i[1:0])));
endmodule

// File: rtl/dta_stage.sv
module dta_stage
  import dta_pkg::*;
#(
  parameter int TEMP_W     = 9,
  parameter int BASE       = 210,
  parameter int SEL_STEP   = 10,
  parameter int STAGE_STEP = 40,
  parameter int HYST       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              valid_i,
  input  logic [1:0]        sel_i,
  input  logic              en_i,
  output stage_t            stage_o,
  output logic              irq_o
);
  localparam int CW = TEMP_W + 2;

  logic [CW-1:0]     temp_ext;
  logic [CW-1:0]     thr [NLIMIT];
  logic [NLIMIT-1:0] up_hit, dn_hit;
  stage_t            up_cnt, dn_cnt;
  stage_t            stage_q, stage_d;
  logic              irq_q, irq_d;

  assign temp_ext = CW'(temp_i);

  for (genvar k = 0; k < NLIMIT; k++) begin : g_lim
    assign thr[k]    = CW'(BASE + STAGE_STEP * k) + CW'(SEL_STEP) * CW'(sel_i);
    assign up_hit[k] = temp_ext >= thr[k];
    assign dn_hit[k] = (temp_ext + CW'(HYST)) >= thr[k];
  end

  always_comb begin
    up_cnt = '0;
    dn_cnt = '0;
    for (int k = 0; k < NLIMIT; k++) begin
      up_cnt = up_cnt + stage_t'(up_hit[k]);
      dn_cnt = dn_cnt + stage_t'(dn_hit[k]);
    end
  end

  always_comb begin
    stage_d = stage_q;
    irq_d   = 1'b0;
    if (!en_i) begin
      stage_d = '0;
    end else if (valid_i) begin
      if (up_cnt > stage_q)      stage_d = up_cnt;
      else if (dn_cnt < stage_q) stage_d = dn_cnt;
      irq_d = (stage_d != stage_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      irq_q   <= irq_d;
    end
  end

  assign stage_o = stage_q;
  assign irq_o   = irq_q;

  assert_irq_means_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (stage_q != $past(stage_q)));
  assert_change_means_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stage_q != $past(stage_q)) && $past(en_i)) |-> irq_q);
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (stage_q == '0 && !irq_q));
  assert_hold_unstrobed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !valid_i) |=> ($stable(stage_q) && !irq_q));
endmodule

// File: rtl/die_temp_alarm.sv
module die_temp_alarm
  import dta_pkg::*;
#(
  parameter int TEMP_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              temp_valid_i,
  input  logic [7:0]        reg_addr_i,
  input  logic              reg_wen_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [1:0]        stage_o,
  output logic              irq_o
);
  logic       rst_n_s;
  logic [1:0] sel;
  logic       en;
  stage_t     stage;

  dta_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dta_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .addr_i  (reg_addr_i),
    .wen_i   (reg_wen_i),
    .wdata_i (reg_wdata_i),
    .stage_i (stage),
    .rdata_o (reg_rdata_o),
    .sel_o   (sel),
    .en_o    (en)
  );

  dta_stage #(.TEMP_W(TEMP_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .temp_i  (temp_i),
    .valid_i (temp_valid_i),
    .sel_i   (sel),
    .en_i    (en),
    .stage_o (stage),
    .irq_o   (irq_o)
  );

  assign stage_o = stage;

  assert_status_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr_i == ADDR_STAT) |-> (reg_rdata_o == {6'b0, stage_o}));
endmodule

// File: tb/die_temp_alarm_tb_top.sv
module die_temp_alarm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] temp;
  logic       tvalid;
  logic [7:0] addr, wdata, rdata;
  logic       wen;
  logic [1:0] stage;
  logic       irq;
  int         total = 0;
  int         bad = 0;
  int         exp_stage = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  die_temp_alarm dut_i (
    .clk(clk), .rst_n(rst_n), .temp_i(temp), .temp_valid_i(tvalid),
    .reg_addr_i(addr), .reg_wen_i(wen), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .stage_o(stage), .irq_o(irq)
  );

  function automatic int lim(input int sel, input int k);
    return 210 + 10 * sel + 40 * k;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  // one valid sample; model step by step; check stage, status and pulse
  task automatic sample(input int t, input int sel, input string req);
    int prev, v;
    prev = exp_stage;
    while (exp_stage < 3 && t >= lim(sel, exp_stage)) exp_stage++;
    while (exp_stage > 0 && t < lim(sel, exp_stage - 1) - 4) exp_stage--;
    @(negedge clk);
    temp = 9'(t); tvalid = 1'b1; addr = 8'h08;
    @(negedge clk);
    tvalid = 1'b0;
    chk({req, " stage"}, stage, exp_stage);
    chk({req, " R10 status"}, rdata, exp_stage);
    chk({req, " R6 irq"}, irq, (prev != exp_stage) ? 1 : 0);
  endtask

  initial begin
    int v;
    rst_n = 1'b0; temp = '0; tvalid = 1'b0; addr = '0; wdata = '0; wen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 stage", stage, 0);
    chk("R1 irq", irq, 0);
    rd(8'h40, v); chk("R1 limit offset", v, 0);
    rd(8'h46, v); chk("R1 enable", v, 0);
    // R2 identification
    rd(8'h04, v); chk("R2 id", v, 8'h09);
    rd(8'h05, v); chk("R2 subid", v, 8'h08);

    // R7 disabled: hot sample leaves stage 0
    exp_stage = 0;
    @(negedge clk); temp = 9'd400; tvalid = 1'b1;
    @(negedge clk); tvalid = 1'b0;
    chk("R7 disabled stage", stage, 0);
    chk("R7 disabled irq", irq, 0);

    wr(8'h46, 8'h80);
    rd(8'h46, v); chk("R7 enable readback", v, 8'h80);

    // R3 R4 R5 R6 sweeps for every offset
    for (int s = 0; s < 4; s++) begin
      wr(8'h40, 8'(s) | 8'hFC);
      rd(8'h40, v); chk("R4 offset readback", v, s);
      sample(0, s, "R5 settle");
      for (int t = 0; t <= 340; t++) sample(t, s, "R3 rise");
      for (int t = 340; t >= 0; t--) sample(t, s, "R5 fall");
    end

    // multi-stage jumps, offset 1
    wr(8'h40, 8'h01);
    sample(300, 1, "R3 jump up");
    chk("R3 jump to 3", stage, 3);
    @(negedge clk); chk("R6 pulse ends", irq, 0);
    sample(215, 1, "R5 jump down");
    chk("R5 jump to 0", stage, 0);

    // R8 unstrobed change
    sample(265, 1, "R8 setup");
    @(negedge clk); temp = 9'd0;
    repeat (3) @(negedge clk);
    chk("R8 unstrobed stage", stage, 2);
    chk("R8 unstrobed irq", irq, 0);

    // R9 unmapped and read-only writes
    wr(8'h41, 8'hFF); wr(8'h08, 8'h00); wr(8'h04, 8'h00); wr(8'h47, 8'h00);
    rd(8'h41, v); chk("R9 unmapped read", v, 0);
    rd(8'hFF, v); chk("R9 unmapped read ff", v, 0);
    rd(8'h04, v); chk("R9 id kept", v, 8'h09);
    rd(8'h40, v); chk("R9 offset kept", v, 1);
    rd(8'h46, v); chk("R9 enable kept", v, 8'h80);
    chk("R9 stage kept", stage, 2);

    // R7 disable mid alarm
    wr(8'h46, 8'h00);
    @(negedge clk);
    chk("R7 forced stage", stage, 0);
    chk("R7 forced irq", irq, 0);
    rd(8'h08, v); chk("R7 status", v, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule